// File: doc/BRIEF.md
# Register Data Consumption Checker

This block watches one source register and the set of downstream registers that may capture its value. Every time the source is loaded, its contents become an outstanding token. The token is retired as soon as any one of the destinations really captures the value. If the source is loaded again while a token is still outstanding, the earlier value has been overwritten without ever being used, and the block reports it.

Each destination is represented by one qualified capture strobe. The strobe is already the AND of that destination's select condition, load enable and clock gate, so the checker only sees events that actually move data. The number of destinations is a parameter, so the same checker can sit beside a single block or across a whole subsystem. It does not compare data values and does not trace paths. It counts load and capture events and nothing else.

A violation gives a one-cycle pulse and sets a flag that only reset clears. A status bit shows whether a token is outstanding.

Top module: `consume_watch`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `pending`, `lost_pulse` and `lost_sticky` are all 0.
- R2: A source load with no capture strobe makes `pending` 1 in the cycle after the clock edge that takes the load.
- R3: When nothing is loaded, a high strobe on any single bit of `dst_take` makes `pending` 0 after the next edge. This holds for every bit index from 0 to N_DEST-1.
- R4: A source load with `pending` at 1 and every `dst_take` bit at 0 raises `lost_pulse` in the cycle after that edge. `pending` stays 1.
- R5: A source load in the same cycle as any capture strobe is not a violation. The old value counts as used, and `pending` is 1 afterwards for the new value.
- R6: The first source load after reset never raises `lost_pulse`.
- R7: A capture strobe while `pending` is 0 and no load is present leaves `pending` at 0 and raises neither `lost_pulse` nor `lost_sticky`.
- R8: `lost_sticky` becomes 1 together with the first `lost_pulse`. It then stays 1 whatever the inputs do, until reset.
- R9: `lost_pulse` is high for exactly one cycle per offending load. It falls after the next edge unless that edge also takes an offending load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| src_load | input | 1 | Source register load enable |
| dst_take | input | N_DEST | Qualified capture strobe for each destination |
| lost_pulse | output | 1 | One-cycle pulse after a load that overwrote unused data |
| lost_sticky | output | 1 | Set on the first loss and held until reset |
| pending | output | 1 | The current source contents have not yet been captured |

## Verification
The hardest case to reach from the ports is a load that arrives while a token is outstanding, in the same cycle as a capture by a destination other than bit 0. That case has to count as consumed, and it also has to re-arm the token. Random traffic reaches it only rarely with sparse strobes. The stimulus therefore forces it directly for each strobe index and then runs long random stretches. In those stretches the load probability is high and the strobes are sparse, which makes back-to-back overwrites and mixed load-and-capture cycles frequent. A mid-run reset confirms that the sticky flag clears and that the first load after it is clean.

// File: rtl/cw_pkg.sv
`timescale 1ns/1ps
package cw_pkg;
  typedef struct packed {
    logic pulse;
    logic sticky;
  } loss_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cw_rst_sync.sv
`timescale 1ns/1ps
module cw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cw_take_merge.sv
`timescale 1ns/1ps
module cw_take_merge #(
  parameter int unsigned N_DEST = 4
) (
  input  logic [N_DEST-1:0] take,
  output logic              any_take
);
  logic [N_DEST:0] or_chain;

  assign or_chain[0] = 1'b0;
  for (genvar gi = 0; gi < N_DEST; gi++) begin : g_or
    assign or_chain[gi+1] = or_chain[gi] | take[gi];
  end

  assign any_take = or_chain[N_DEST];
endmodule

// File: rtl/cw_token.sv
`timescale 1ns/1ps
module cw_token (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic any_take,
  output logic pend,
  output logic overwrite
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en   = load | any_take;
    pend_d    = load;
    overwrite = load & pend_q & ~any_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend = pend_q;

  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pend_q); // R2
  AST_TAKE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && any_take) |=> !pend_q); // R3
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !pend_q) |=> !pend_q); // R7
endmodule

// File: rtl/cw_loss_flag.sv
`timescale 1ns/1ps
module cw_loss_flag
  import cw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  overwrite,
  output loss_t loss
);
  loss_t loss_q, loss_d;

  always_comb begin
    loss_d.pulse  = overwrite;
    loss_d.sticky = loss_q.sticky | overwrite;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loss_q <= '0;
    else        loss_q <= loss_d;
  end

  assign loss = loss_q;

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    loss_q.sticky |=> loss_q.sticky); // R8
  AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loss_q.pulse |-> loss_q.sticky); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_q.pulse && !overwrite) |=> !loss_q.pulse); // R9
endmodule

// File: rtl/consume_watch.sv
`timescale 1ns/1ps
module consume_watch
  import cw_pkg::*;
#(
  parameter int unsigned N_DEST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_load,
  input  logic [N_DEST-1:0] dst_take,
  output logic              lost_pulse,
  output logic              lost_sticky,
  output logic              pending
);
  logic  rst_n_int;
  logic  any_take;
  logic  pend;
  logic  overwrite;
  loss_t loss;

  cw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cw_take_merge #(.N_DEST(N_DEST)) u_merge (
    .take     (dst_take),
    .any_take (any_take)
  );

  cw_token u_token (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (src_load),
    .any_take  (any_take),
    .pend      (pend),
    .overwrite (overwrite)
  );

  cw_loss_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .overwrite (overwrite),
    .loss      (loss)
  );

  assign lost_pulse  = loss.pulse;
  assign lost_sticky = loss.sticky;
  assign pending     = pend;

  AST_LOSS_REPORTED: assert property (@(posedge clk) disable iff (!rst_n_int)
    (src_load && pending && dst_take == '0) |=> lost_pulse); // R4
  AST_TAKE_SAVES: assert property (@(posedge clk) disable iff (!rst_n_int)
    (src_load && dst_take != '0) |=> (!lost_pulse && pending)); // R5
  AST_NO_LOSS_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!pending) |=> !lost_pulse); // R6
endmodule

// File: tb/consume_watch_bench.sv
`timescale 1ns/1ps
module consume_watch_bench;
  localparam int unsigned N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         src_load;
  logic [N-1:0] dst_take;
  logic         lost_pulse, lost_sticky, pending;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic m_pend, m_sticky, m_pulse;

  always #5 clk = ~clk;

  consume_watch #(.N_DEST(N)) u_consume_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_load    (src_load),
    .dst_take    (dst_take),
    .lost_pulse  (lost_pulse),
    .lost_sticky (lost_sticky),
    .pending     (pending)
  );

  function automatic logic f_viol(logic p, logic ld, logic [N-1:0] tk);
    return ld & p & ~(|tk);
  endfunction

  function automatic logic f_pend(logic p, logic ld, logic [N-1:0] tk);
    if (ld) return 1'b1;
    if (|tk) return 1'b0;
    return p;
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    check(req, pending, m_pend, "pending");
    check(req, lost_pulse, m_pulse, "lost_pulse");
    check(req, lost_sticky, m_sticky, "lost_sticky");
  endtask

  // apply inputs while clk is low, advance one edge, compare at the next falling edge
  task automatic cyc(logic ld, logic [N-1:0] tk, string req);
    logic v;
    src_load = ld;
    dst_take = tk;
    v        = f_viol(m_pend, ld, tk);
    m_pend   = f_pend(m_pend, ld, tk);
    m_pulse  = v;
    m_sticky = m_sticky | v;
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic do_reset();
    src_load = 1'b0;
    dst_take = '0;
    rst_n    = 1'b0;
    m_pend = 1'b0; m_pulse = 1'b0; m_sticky = 1'b0;
    #1;
    check_all("R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    cyc(1'b1, '0, "R6");
    cyc(1'b0, '0, "R2");
    for (int i = 0; i < N; i++) begin
      cyc(1'b0, N'(1) << i, "R3");
      cyc(1'b0, N'(1) << i, "R7");
      cyc(1'b1, '0, "R2");
    end
    cyc(1'b1, '0, "R4");
    cyc(1'b0, '0, "R9");
    cyc(1'b1, '0, "R4");
    cyc(1'b1, '0, "R9");
    cyc(1'b0, '0, "R9");
    for (int i = 0; i < N; i++) begin
      cyc(1'b1, N'(1) << i, "R5");
    end
    cyc(1'b1, '1, "R5");
    cyc(1'b0, 4'b0101, "R3");
    cyc(1'b0, '0, "R8");

    for (int n = 0; n < 3000; n++) begin
      logic         ld;
      logic [N-1:0] tk;
      ld = ($urandom_range(0, 99) < 55);
      tk = '0;
      for (int b = 0; b < N; b++) tk[b] = ($urandom_range(0, 99) < 12);
      cyc(ld, tk, "R2 R3 R4 R5 R8 R9");
    end

    do_reset();
    cyc(1'b1, '0, "R6");
    cyc(1'b0, 4'b0010, "R3");
    cyc(1'b0, 4'b1000, "R7");
    for (int n = 0; n < 1000; n++) begin
      logic         ld;
      logic [N-1:0] tk;
      ld = ($urandom_range(0, 99) < 30);
      tk = '0;
      for (int b = 0; b < N; b++) tk[b] = ($urandom_range(0, 99) < 25);
      cyc(ld, tk, "R2 R3 R4 R5 R7 R9");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule